// File: doc/BRIEF.md
# Pin Event Interrupt Unit

This block watches 64 general-purpose input lines and turns chosen events on them into a single interrupt request for a parent interrupt controller. Each line has its own settings. It can react to an edge or to a level. In edge mode it can react to one edge or to both edges. A polarity bit picks rising or high when set, and falling or low when clear. An enable bit lets the line reach the interrupt output. A global enable gates the whole output.

Inputs pass through a two-flop synchronizer and are then compared with their value from the previous cycle. A detected edge is latched in a raw event word. The latched bit stays set until software writes a one to the matching bit of a clear word. A masked view shows, for each line, whether it is enabled and its event or level condition is present. The interrupt output is the OR of that masked view, qualified by the global enable. Software reaches everything through a small word-addressed register port. Reads are combinational. Writes take effect at the clock edge.

Top module: `pin_event_irq`

## Requirements
- R1: After reset, every readable word reads zero and `irq_o` is low.
- R2: Registers are 32-bit words at word-aligned byte addresses. Each per-line item is a pair of words: the lower address holds lines 0-31 and the address 4 above holds lines 32-63. Line n sits at bit n mod 32. The map is: 0x00 global enable (bit 0 only), 0x08/0x0C mode (1 = edge, 0 = level), 0x10/0x14 dual-edge select, 0x18/0x1C polarity, 0x20/0x24 line enable, 0x28/0x2C clear, 0x30/0x34 raw event, 0x38/0x3C masked view. Configuration words read back what was written.
- R3: A line in edge mode with dual-edge at 0 latches its raw event bit on a rising edge when polarity is 1, or on a falling edge when polarity is 0. It ignores the opposite edge. The bit stays set after the input returns.
- R4: A line in edge mode with dual-edge at 1 latches its raw event bit on both rising and falling edges.
- R5: Writing a clear word clears the raw event bits where the written data has ones. Bits written as zero are unchanged. The clear words always read zero.
- R6: If a clear and a newly detected edge hit the same line in the same cycle, the raw event bit stays set.
- R7: A line in level mode never sets its raw event bit. Its masked bit follows the synchronized input without latching: it is set while the input equals the polarity bit and the line is enabled.
- R8: A masked bit is set only when its line enable is 1. A line with enable 0 does not drive `irq_o`.
- R9: `irq_o` is high exactly when the global enable bit is 1 and at least one masked bit is set. Clearing the global enable leaves the masked view unchanged.
- R10: An input change driven before clock edge k shows in the raw event word after edge k+2, and in a level-mode masked bit after edge k+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle, zero when no read is requested |
| pins_i | input | 64 | Asynchronous input lines |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clear write that lands in the same cycle in which a new edge is latched on the same line. The bench drives that line in dual-edge mode so it already holds a latched bit. It then toggles the input at a known falling clock edge and presents the clear write exactly two rising edges later, so the write is sampled at the edge that latches the new event. A second clear with no edge pending then shows that the write itself was effective.

// File: rtl/pei_pkg.sv
`timescale 1ns/1ps
package pei_pkg;
  // Address group codes, taken from byte address bits [5:3]
  localparam logic [2:0] GRP_GEN  = 3'd0;
  localparam logic [2:0] GRP_MODE = 3'd1;
  localparam logic [2:0] GRP_DUAL = 3'd2;
  localparam logic [2:0] GRP_POL  = 3'd3;
  localparam logic [2:0] GRP_ENA  = 3'd4;
  localparam logic [2:0] GRP_CLR  = 3'd5;
  localparam logic [2:0] GRP_RAW  = 3'd6;
  localparam logic [2:0] GRP_MSK  = 3'd7;
endpackage

// File: rtl/pei_rst_sync.sv
`timescale 1ns/1ps
module pei_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/pei_in_sync.sv
`timescale 1ns/1ps
module pei_in_sync #(
  parameter int LINES  = 64,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_i,
  output logic [LINES-1:0] sync_o
);
  logic [LINES-1:0] chain_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= '0;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/pei_regs.sv
`timescale 1ns/1ps
module pei_regs
  import pei_pkg::*;
#(
  parameter int LINES  = 64,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        grp,
  input  logic              half,
  input  logic [WORD_W-1:0] wdata,
  output logic              gen_q,
  output logic [LINES-1:0]  mode_q,
  output logic [LINES-1:0]  dual_q,
  output logic [LINES-1:0]  pol_q,
  output logic [LINES-1:0]  ena_q,
  output logic [LINES-1:0]  clr_o
);
  logic             gen_d;
  logic [LINES-1:0] mode_d, dual_d, pol_d, ena_d;
  logic             gen_ce, mode_ce, dual_ce, pol_ce, ena_ce;

  // Replace one half of a line vector with a written word
  function automatic logic [LINES-1:0] place(input logic [LINES-1:0] cur,
                                             input logic hi,
                                             input logic [WORD_W-1:0] w);
    logic [LINES-1:0] r;
    r = cur;
    if (hi) r[LINES-1:WORD_W] = w;
    else    r[WORD_W-1:0]     = w;
    return r;
  endfunction

  always_comb begin
    gen_ce  = wr_en && (grp == GRP_GEN) && !half;
    mode_ce = wr_en && (grp == GRP_MODE);
    dual_ce = wr_en && (grp == GRP_DUAL);
    pol_ce  = wr_en && (grp == GRP_POL);
    ena_ce  = wr_en && (grp == GRP_ENA);
    gen_d   = wdata[0];
    mode_d  = place(mode_q, half, wdata);
    dual_d  = place(dual_q, half, wdata);
    pol_d   = place(pol_q,  half, wdata);
    ena_d   = place(ena_q,  half, wdata);
    clr_o   = (wr_en && (grp == GRP_CLR)) ? place('0, half, wdata) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= 1'b0;
      mode_q <= '0;
      dual_q <= '0;
      pol_q  <= '0;
      ena_q  <= '0;
    end else begin
      if (gen_ce)  gen_q  <= gen_d;
      if (mode_ce) mode_q <= mode_d;
      if (dual_ce) dual_q <= dual_d;
      if (pol_ce)  pol_q  <= pol_d;
      if (ena_ce)  ena_q  <= ena_d;
    end
  end
endmodule

// File: rtl/pei_detect.sv
`timescale 1ns/1ps
module pei_detect #(
  parameter int LINES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lvl_i,
  input  logic [LINES-1:0] mode_i,
  input  logic [LINES-1:0] dual_i,
  input  logic [LINES-1:0] pol_i,
  input  logic [LINES-1:0] clr_i,
  output logic [LINES-1:0] raw_q,
  output logic [LINES-1:0] lvl_hit_o
);
  logic [LINES-1:0] prev_q;
  logic [LINES-1:0] rise, fall, edge_hit, raw_d;

  always_comb begin
    rise      = lvl_i & ~prev_q;
    fall      = ~lvl_i & prev_q;
    edge_hit  = mode_i & ((dual_i & (rise | fall)) |
                          (~dual_i & pol_i & rise) |
                          (~dual_i & ~pol_i & fall));
    // a fresh edge overrides a clear in the same cycle
    raw_d     = (raw_q & ~clr_i) | edge_hit;
    lvl_hit_o = ~mode_i & ~(lvl_i ^ pol_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      raw_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      raw_q  <= raw_d;
    end
  end
endmodule

// File: rtl/pin_event_irq.sv
`timescale 1ns/1ps
module pin_event_irq
  import pei_pkg::*;
#(
  parameter int LINES  = 64,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [LINES-1:0]  pins_i,
  output logic              irq_o
);
  localparam int GRP_LSB = ADDR_W - 3;

  logic             rst_sync_n;
  logic [LINES-1:0] lvl, mode_q, dual_q, pol_q, ena_q, clr, raw_q, lvl_hit, masked;
  logic             gen_q, aligned, wr_en, rd_en, half;
  logic [2:0]       grp;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign wr_en   = bus_valid && bus_write && aligned;
  assign rd_en   = bus_valid && !bus_write && aligned;
  assign grp     = bus_addr[ADDR_W-1:GRP_LSB];
  assign half    = bus_addr[2];

  pei_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  pei_in_sync #(.LINES(LINES), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .async_i(pins_i), .sync_o(lvl));

  pei_regs #(.LINES(LINES), .WORD_W(WORD_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .grp(grp), .half(half),
    .wdata(bus_wdata), .gen_q(gen_q), .mode_q(mode_q), .dual_q(dual_q),
    .pol_q(pol_q), .ena_q(ena_q), .clr_o(clr));

  pei_detect #(.LINES(LINES)) u_det (
    .clk(clk), .rst_n(rst_sync_n), .lvl_i(lvl), .mode_i(mode_q),
    .dual_i(dual_q), .pol_i(pol_q), .clr_i(clr), .raw_q(raw_q),
    .lvl_hit_o(lvl_hit));

  assign masked = ena_q & (raw_q | lvl_hit);
  assign irq_o  = gen_q & (|masked);

  function automatic logic [WORD_W-1:0] pick(input logic [LINES-1:0] v, input logic hi);
    return hi ? v[LINES-1:WORD_W] : v[WORD_W-1:0];
  endfunction

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      case (grp)
        GRP_GEN:  bus_rdata = half ? '0 : {{(WORD_W-1){1'b0}}, gen_q};
        GRP_MODE: bus_rdata = pick(mode_q, half);
        GRP_DUAL: bus_rdata = pick(dual_q, half);
        GRP_POL:  bus_rdata = pick(pol_q, half);
        GRP_ENA:  bus_rdata = pick(ena_q, half);
        GRP_RAW:  bus_rdata = pick(raw_q, half);
        GRP_MSK:  bus_rdata = pick(masked, half);
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pei_chk.sv
`timescale 1ns/1ps
module pei_chk #(
  parameter int LINES  = 64,
  parameter int WORD_W = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic [LINES-1:0]  raw,
  input logic [LINES-1:0]  mode,
  input logic              irq_o
);
  // R9
  en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_write && bus_addr == '0 && !bus_wdata[0]) |=> !irq_o);

  // R5
  clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(raw) & ~raw)) |->
      ($past(bus_valid) && $past(bus_write) && ($past(bus_addr[ADDR_W-1:ADDR_W-3]) == 3'd5)));

  // R3
  raw_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw & ~$past(raw) & ~$past(mode)) == '0));

  // R5
  clr_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr[ADDR_W-1:ADDR_W-3] == 3'd5) |-> (bus_rdata == '0));
endmodule

bind pin_event_irq pei_chk #(.LINES(LINES), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_sync_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .raw(raw_q), .mode(mode_q), .irq_o(irq_o));

// File: tb/test_pin_event_irq.sv
`timescale 1ns/1ps
module test_pin_event_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] pins = '0;
  logic        irq_o;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pin_event_irq i_pin_event_irq (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pins_i(pins), .irq_o(irq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #0.5 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 64; a += 4) begin
      rd(a[5:0], v);
      chk("R1 word zero after reset", v, 32'h0);
    end
    chk("R1 irq low after reset", {31'b0, irq_o}, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(6'h08, 32'hA5A5_0001); wr(6'h0C, 32'h1234_5678); wr(6'h24, 32'h0F0F_F0F0);
    wr(6'h00, 32'hFFFF_FFFF);
    rd(6'h08, v); chk("R2 mode low word", v, 32'hA5A5_0001);
    rd(6'h0C, v); chk("R2 mode high word", v, 32'h1234_5678);
    rd(6'h24, v); chk("R2 enable high word", v, 32'h0F0F_F0F0);
    rd(6'h20, v); chk("R2 enable low word untouched", v, 32'h0);
    rd(6'h00, v); chk("R2 global enable bit0 only", v, 32'h1);
    wr(6'h2C, 32'hFFFF_FFFF);
    rd(6'h2C, v); chk("R5 clear word reads zero", v, 32'h0);
    wr(6'h08, 0); wr(6'h0C, 0); wr(6'h24, 0); wr(6'h00, 0);
  endtask

  task automatic t_single_edge;
    logic [31:0] v;
    wr(6'h00, 1); wr(6'h0C, 32'h100); wr(6'h1C, 32'h100); wr(6'h24, 32'h100);
    pins[40] = 1'b1;
    wait_n(2);
    rd(6'h34, v); chk("R10 raw not yet set after two edges", v, 32'h0);
    wait_n(1);
    rd(6'h34, v); chk("R3 R10 rising edge latched line 40", v, 32'h100);
    chk("R9 irq from line 40", {31'b0, irq_o}, 32'h1);
    pins[40] = 1'b0;
    wait_n(5);
    rd(6'h34, v); chk("R3 bit stays set after input falls", v, 32'h100);
    wr(6'h34, 32'hFFFF_FEFF);
    rd(6'h34, v); chk("R5 zero bits leave raw set", v, 32'h100);
    wr(6'h2C, 32'h100);
    rd(6'h34, v); chk("R5 clear by one", v, 32'h0);
    chk("R5 irq low after clear", {31'b0, irq_o}, 32'h0);
    // falling polarity on line 3
    wr(6'h08, 32'h8); wr(6'h20, 32'h8);
    pins[3] = 1'b1;
    wait_n(5);
    rd(6'h30, v); chk("R3 rising edge ignored for falling polarity", v, 32'h0);
    pins[3] = 1'b0;
    wait_n(4);
    rd(6'h30, v); chk("R3 falling edge latched line 3", v, 32'h8);
    wr(6'h28, 32'h8);
    rd(6'h30, v); chk("R5 clear line 3", v, 32'h0);
  endtask

  task automatic t_dual_and_collide;
    logic [31:0] v;
    wr(6'h0C, 32'h8000_0100); wr(6'h14, 32'h8000_0000); wr(6'h24, 32'h8000_0100);
    pins[63] = 1'b1;
    wait_n(4);
    rd(6'h34, v); chk("R4 dual mode rising edge", v, 32'h8000_0000);
    wr(6'h2C, 32'h8000_0000);
    pins[63] = 1'b0;
    wait_n(4);
    rd(6'h34, v); chk("R4 dual mode falling edge", v, 32'h8000_0000);
    // clear written in the cycle the next edge is latched
    pins[63] = 1'b1;
    wait_n(2);
    wr(6'h2C, 32'h8000_0000);
    rd(6'h34, v); chk("R6 edge wins over same-cycle clear", v, 32'h8000_0000);
    wait_n(3);
    wr(6'h2C, 32'h8000_0000);
    rd(6'h34, v); chk("R6 later clear is effective", v, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] v;
    wr(6'h18, 32'h20); wr(6'h20, 32'h28);
    pins[5] = 1'b1;
    wait_n(1);
    rd(6'h38, v); chk("R10 level not yet after one edge", v, 32'h0);
    wait_n(1);
    rd(6'h38, v); chk("R7 R10 high level masked", v, 32'h20);
    chk("R9 irq from level line", {31'b0, irq_o}, 32'h1);
    rd(6'h30, v); chk("R7 level line leaves raw clear", v, 32'h0);
    pins[5] = 1'b0;
    wait_n(3);
    rd(6'h38, v); chk("R7 level not latched", v, 32'h0);
    chk("R7 irq drops with level", {31'b0, irq_o}, 32'h0);
    wr(6'h18, 32'h0);
    rd(6'h38, v); chk("R7 low level active with polarity 0", v, 32'h20);
    wr(6'h00, 0);
    chk("R9 global enable off blocks irq", {31'b0, irq_o}, 32'h0);
    rd(6'h38, v); chk("R9 masked view kept while disabled", v, 32'h20);
    wr(6'h00, 1);
    chk("R9 irq returns with global enable", {31'b0, irq_o}, 32'h1);
    wr(6'h20, 32'h8);
    rd(6'h38, v); chk("R8 disabled line not masked", v, 32'h0);
    chk("R8 disabled line no irq", {31'b0, irq_o}, 32'h0);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(3);
    t_reset();
    t_regs();
    t_single_edge();
    t_dual_and_collide();
    t_level();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule